// File: doc/BRIEF.md
# Interval Timer Command and Status Unit

This unit owns three independent interval timers, labelled A, B and C, and exposes them through one command channel and one response channel. Each command carries an area code, a 16-bit modifier and a 16-bit data word. A run-control command starts or stops all three timers at once, one data bit per timer. A reload command programs the value a timer counts down from. A sense command returns a status word that shows which timers have a pending interrupt request. If one modifier bit is set, the same sense command also clears those requests.

Each running timer counts down by one on every pulse of the shared `tick` input. When it passes zero it raises its request flag and starts again from its reload value. The single `irq` output is asserted while any request flag is set. Words are numbered most-significant-first: word bit 0 is vector bit [15], and word bit 15 is vector bit [0].

Both channels use valid/ready. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. A sense response is held on `rsp_data` with `rsp_valid` high until `rsp_ready` is seen. While a response waits, `cmd_ready` is low, so back-pressure on the response channel stalls the command channel. The other command types produce no response.

Top module: `itmr_ctrl`

## Requirements
- R1: A command is accepted when `cmd_valid && cmd_ready`. `cmd_ready` is low exactly when a response is held and `rsp_ready` is low. A held response keeps `rsp_valid` high and `rsp_data` unchanged until it is taken.
- R2: A command is decoded only when `cmd_area` is zero, using `cmd_mod[7:5]`: 3'b001 is run control, 3'b010 is sense, 3'b011 is reload. Any other area or code is accepted but changes no timer, flag or response.
- R3: Run control sets the run flags of A, B and C from `cmd_data[15]`, `[14]` and `[13]` (1 runs, 0 stops). All three flags are updated by every such command. A timer that goes from stopped to running loads its count from its reload value.
- R4: On a `tick` pulse, a running timer whose count is zero sets its request flag and reloads; otherwise it decrements. The first request therefore comes on the (reload+1)-th tick after start. A stopped timer holds its count, raises nothing, and a stop takes priority over a tick in the same cycle.
- R5: Reload stores `cmd_data[CNT_W-1:0]` into the timer chosen by `cmd_mod[2:1]` (0 = A, 1 = B, 2 = C; 3 writes nothing). The count in progress is not changed.
- R6: A sense command raises `rsp_valid` on the cycle after acceptance. `rsp_data[15]`, `[14]` and `[13]` hold the A, B and C request flags as they stood before the accepting edge, and `rsp_data[12:0]` is zero.
- R7: When `cmd_mod[0]` of a sense command is 1, the request flags are cleared at the accepting edge. When it is 0, they are kept.
- R8: A request raised on the same edge as a clearing sense remains set afterwards.
- R9: `irq` is high exactly when at least one request flag is set.
- R10: After reset, all timers are stopped, every reload and count is zero, no flag is set, no response is held and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count-enable pulse shared by all timers |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_area | input | AREA_W | Area code; zero selects this unit |
| cmd_mod | input | 16 | Modifier: operation code, timer select, clear bit |
| cmd_data | input | 16 | Run bits or reload value |
| rsp_valid | output | 1 | Status word held |
| rsp_ready | input | 1 | Consumer takes the status word |
| rsp_data | output | 16 | Status word |
| irq | output | 1 | Any timer request pending |

## Verification
The two functions that can fall in the same cycle are a timer expiring and a clearing sense command. The bench provokes the overlap by holding `tick` high in the very cycle a clearing sense is accepted, with a timer reloaded to zero so that it expires on that edge. The expected result is that the returned word still shows the flag that was already set, that `irq` stays high afterwards, and that a second clearing sense without a tick leaves `irq` low. A second overlap, a command offered while a response is stalled, is judged by the command having no effect.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  localparam int NUM_TMR = 3;
  localparam int WORD_W  = 16;

  localparam logic [2:0] OP_RUN    = 3'b001;
  localparam logic [2:0] OP_SENSE  = 3'b010;
  localparam logic [2:0] OP_RELOAD = 3'b011;

  typedef struct packed {
    logic       run_wr;
    logic       sense;
    logic       clr;
    logic       reload_wr;
    logic [1:0] sel;
  } itmr_dec_t;

endpackage

// File: rtl/itmr_decode.sv
module itmr_decode
  import itmr_pkg::*;
#(
  parameter int AREA_W = 5
) (
  input  logic                fire,
  input  logic [AREA_W-1:0]   area,
  input  logic [WORD_W-1:0]   mod,
  output itmr_dec_t           dec
);

  logic       mine;
  logic [2:0] op;

  assign mine = fire && (area == '0);
  assign op   = mod[7:5];

  always_comb begin
    dec = '0;
    dec.sel = mod[2:1];
    dec.clr = mod[0];
    if (mine) begin
      case (op)
        OP_RUN:    dec.run_wr    = 1'b1;
        OP_SENSE:  dec.sense     = 1'b1;
        OP_RELOAD: dec.reload_wr = 1'b1;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/itmr_timer.sv
module itmr_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run_wr,
  input  logic             run_bit,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] reload_val,
  output logic             running,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rld_q;
  logic             run_q;
  logic             start;
  logic             keep;

  assign start   = run_wr && run_bit && !run_q;
  assign keep    = run_q && !(run_wr && !run_bit);
  assign expire  = keep && tick && (cnt_q == '0);
  assign running = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      if (reload_wr) rld_q <= reload_val;
      if (run_wr) run_q <= run_bit;
      if (start) begin
        cnt_q <= rld_q;
      end else if (keep && tick) begin
        if (cnt_q == '0) cnt_q <= rld_q;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/itmr_status.sv
module itmr_status
  import itmr_pkg::*;
#(
  parameter int NUM = NUM_TMR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM-1:0]    expire,
  input  logic              sense,
  input  logic              clr,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic [NUM-1:0]    req
);

  logic [NUM-1:0]    req_q;
  logic [NUM-1:0]    req_d;
  logic [WORD_W-1:0] word;

  always_comb begin
    req_d = (sense && clr) ? '0 : req_q;
    req_d = req_d | expire;
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM; i++) word[WORD_W-1-i] = req_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      req_q <= req_d;
      if (sense) begin
        rsp_valid <= 1'b1;
        rsp_data  <= word;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assign req = req_q;

endmodule

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
  import itmr_pkg::*;
#(
  parameter int AREA_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [AREA_W-1:0] cmd_area,
  input  logic [15:0]       cmd_mod,
  input  logic [15:0]       cmd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [15:0]       rsp_data,
  output logic              irq
);

  itmr_dec_t          dec;
  logic               fire;
  logic [NUM_TMR-1:0] run_vec;
  logic [NUM_TMR-1:0] exp_vec;
  logic [NUM_TMR-1:0] req_vec;

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign fire      = cmd_valid && cmd_ready;

  itmr_decode #(.AREA_W(AREA_W)) u_dec (
    .fire (fire),
    .area (cmd_area),
    .mod  (cmd_mod),
    .dec  (dec)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    itmr_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .run_wr     (dec.run_wr),
      .run_bit    (cmd_data[WORD_W-1-g]),
      .reload_wr  (dec.reload_wr && (dec.sel == 2'(g))),
      .reload_val (cmd_data[CNT_W-1:0]),
      .running    (run_vec[g]),
      .expire     (exp_vec[g])
    );
  end

  itmr_status #(.NUM(NUM_TMR)) u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (exp_vec),
    .sense     (dec.sense),
    .clr       (dec.clr),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .req       (req_vec)
  );

  assign irq = |req_vec;

endmodule

// File: rtl/itmr_ctrl_chk.sv
module itmr_ctrl_chk #(
  parameter int AREA_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [AREA_W-1:0] cmd_area,
  input logic [15:0]       cmd_mod,
  input logic [15:0]       cmd_data,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [15:0]       rsp_data,
  input logic              irq,
  input logic [2:0]        run_vec,
  input logic [2:0]        req_vec
);

  logic acc, is_run, is_sense, is_known;
  assign acc      = cmd_valid && cmd_ready;
  assign is_run   = (cmd_area == '0) && (cmd_mod[7:5] == 3'b001);
  assign is_sense = (cmd_area == '0) && (cmd_mod[7:5] == 3'b010);
  assign is_known = (cmd_area == '0) && (cmd_mod[7:5] inside {3'b001, 3'b010, 3'b011});

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R1
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !cmd_ready); // R1
  AST_UNKNOWN_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !is_known |=> $stable(run_vec)); // R2
  AST_RUN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_run |=> run_vec == {$past(cmd_data[13]), $past(cmd_data[14]), $past(cmd_data[15])}); // R3
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (req_vec & ~$past(req_vec)) == 3'b000); // R4
  AST_SENSE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_sense |=> rsp_valid); // R6
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_data[12:0] == 13'd0); // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_sense && cmd_mod[0] && !tick |=> !irq); // R7
  AST_KEEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_sense && !cmd_mod[0] && !tick |=> req_vec == $past(req_vec)); // R7

endmodule

bind itmr_ctrl itmr_ctrl_chk #(.AREA_W(AREA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_area  (cmd_area),
  .cmd_mod   (cmd_mod),
  .cmd_data  (cmd_data),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .irq       (irq),
  .run_vec   (run_vec),
  .req_vec   (req_vec)
);

// File: tb/itmr_ctrl_test.sv
module itmr_ctrl_test;

  localparam int AW = 5;
  localparam int CW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [AW-1:0] cmd_area = '0;
  logic [15:0] cmd_mod = '0;
  logic [15:0] cmd_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  itmr_ctrl #(.AREA_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_area(cmd_area),
    .cmd_mod(cmd_mod), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .irq(irq)
  );

  function automatic logic [15:0] mw(input logic [2:0] op, input logic [1:0] sel, input logic clr);
    logic [15:0] m = '0;
    m[7:5] = op; m[2:1] = sel; m[0] = clr;
    return m;
  endfunction

  function automatic logic [15:0] runw(input logic [2:0] p);
    return {p[0], p[1], p[2], 13'd0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [AW-1:0] a, input logic [15:0] m,
                      input logic [15:0] d, input logic tk);
    cmd_valid = v; cmd_area = a; cmd_mod = m; cmd_data = d; tick = tk;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; tick = 1'b0;
  endtask

  task automatic run_cmd(input logic [2:0] p);
    step(1'b1, '0, mw(3'b001, 2'd0, 1'b0), runw(p), 1'b0);
  endtask
  task automatic sense(input logic clr);
    step(1'b1, '0, mw(3'b010, 2'd0, clr), 16'd0, 1'b0);
  endtask
  task automatic reload(input logic [1:0] sel, input logic [15:0] v);
    step(1'b1, '0, mw(3'b011, sel, 1'b0), v, 1'b0);
  endtask
  task automatic tk1();
    step(1'b0, '0, 16'd0, 16'd0, 1'b1);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int errs;
    logic [2:0] p;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 irq", irq, 0);
    check("R10 rsp_valid", rsp_valid, 0);
    check("R10 cmd_ready", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    tk1();
    check("R10 no request after tick", irq, 0);

    // R3 R4 R6: exhaustive reload sweep per timer
    for (int t = 0; t < 3; t++) begin
      for (int r = 0; r < 16; r++) begin
        run_cmd(3'b000);
        sense(1'b1);
        reload(2'(t), 16'(r));
        p = 3'b000; p[t] = 1'b1;
        run_cmd(p);
        errs = 0;
        for (int k = 1; k <= r + 1; k++) begin
          tk1();
          if (irq !== (k == r + 1)) errs++;
        end
        check("R4 expiry tick count", errs, 0);
        sense(1'b0);
        check("R6 status word", rsp_data, 32'(16'h8000 >> t));
      end
    end

    // R5: zero reloads, select 3 writes nothing
    run_cmd(3'b000);
    sense(1'b1);
    reload(2'd0, 0); reload(2'd1, 0); reload(2'd2, 0);
    reload(2'd3, 16'd9);
    run_cmd(3'b111);
    tk1();
    sense(1'b1);
    check("R5 sel3 ignored", rsp_data, 16'hE000);

    // R3 R7 R9: every run pattern
    for (int q = 0; q < 8; q++) begin
      run_cmd(3'b000);
      sense(1'b1);
      run_cmd(3'(q));
      tk1();
      check("R9 irq or", irq, (q != 0));
      sense(1'b0);
      check("R3 pattern flags", rsp_data, runw(3'(q)));
      sense(1'b1);
      check("R7 kept flags", rsp_data, runw(3'(q)));
      check("R7 cleared", irq, 0);
    end

    // R2 ignored commands
    run_cmd(3'b000);
    sense(1'b1);
    step(1'b1, 5'd1, mw(3'b001, 2'd0, 1'b0), 16'hFFFF, 1'b0);
    step(1'b1, '0, mw(3'b111, 2'd0, 1'b0), 16'hFFFF, 1'b0);
    check("R2 no response", rsp_valid, 0);
    tk1();
    check("R2 timers still stopped", irq, 0);

    // R5 reload does not disturb running count
    reload(2'd0, 16'd3);
    run_cmd(3'b001);
    tk1();
    reload(2'd0, 16'd0);
    tk1(); tk1();
    check("R5 count kept", irq, 0);
    tk1();
    check("R5 expiry after old count", irq, 1);

    // R8 same-cycle expiry and clearing sense (A reload 0, running)
    sense(1'b1);
    tk1();
    check("R8 flag set", irq, 1);
    step(1'b1, '0, mw(3'b010, 2'd0, 1'b1), 16'd0, 1'b1);
    check("R8 response shows old flag", rsp_data, 16'h8000);
    check("R8 flag survives clear", irq, 1);
    sense(1'b1);
    check("R8 plain clear", irq, 0);

    // R4 stop wins over tick
    step(1'b1, '0, mw(3'b001, 2'd0, 1'b0), 16'd0, 1'b1);
    check("R4 stop beats tick", irq, 0);

    // R1 back-pressure
    rsp_ready = 1'b0;
    sense(1'b0);
    check("R1 rsp_valid held", rsp_valid, 1);
    check("R1 cmd_ready low", cmd_ready, 0);
    step(1'b1, '0, mw(3'b001, 2'd0, 1'b0), 16'hE000, 1'b0);
    check("R1 still held", rsp_valid, 1);
    check("R1 data stable", rsp_data, 16'h0000);
    rsp_ready = 1'b1;
    step(1'b0, '0, 16'd0, 16'd0, 1'b0);
    check("R1 released", rsp_valid, 0);
    tk1();
    check("R1 stalled command had no effect", irq, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule